// File: doc/BRIEF.md
# Changed-Only Configuration Sync over SPI

This block holds the configuration of an external serially programmed device as a bank of 32-bit shadow words. Next to it sits a record of what the device was last given. A sync pass compares the two and shifts out only the words that differ, as 32-bit SPI frames. The low bits of each frame carry the word's index, so the device can route it.

A host port writes shadow words and reads back the written record. Every accepted host write starts a sync, and so does a dedicated power-down control that toggles a single bit of word 2. Two of the words only take effect once word 0 is loaded, so whenever either is sent, word 0 is sent again to close the pass. Requests that arrive during a pass are held and served by one more pass straight after it.

Top module: `cfg_shadow_sync`

## Requirements
- R1: Each frame is exactly 32 bits, shifted most significant bit first, and equals the shadow word with its register index (0 to 5) in bits 2:0.
- R2: A pass visits the indices in falling order, 5 first and 0 last, so any frames of one pass leave in that order.
- R3: A word whose shadow equals its written record is not sent. A sync with no differences sends no frame but still raises `busy` for the pass.
- R4: When word 1 or word 4 is sent in a pass, word 0 is sent at the end of that same pass, even if word 0 is unchanged.
- R5: After reset every written-record entry reads 0xFFFFFFFF and every shadow word is zero, so the first sync sends all six words (frames 5,4,3,2,1,0 carrying only their index).
- R6: A host write to index 0..5 stores the data with bits 2:0 forced to zero and starts a sync. A host write to index 6 or 7 changes nothing and sends no frame.
- R7: `host_rdata` shows the written-record entry for `host_addr`, not the shadow. It changes only when that word's frame completes, and reads 0 for index 6 or 7.
- R8: `pd_wr` sets bit 5 of shadow word 2 to `pd_val` and starts a sync, which sends word 2 when the bit changed.
- R9: SPI mode 0. `spi_sclk` idles low and is low when `spi_cs_n` falls. `spi_mosi` is stable while `spi_sclk` is high. `spi_cs_n` stays low for exactly 32 `spi_sclk` rising edges. `spi_load` is a one-cycle pulse in the cycle `spi_cs_n` returns high.
- R10: `busy` rises the cycle after a sync request and falls only after the last frame of the last pass. A request arriving while busy runs one further full pass without `busy` dropping in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Word index for write and readback |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Written-record entry at `host_addr` |
| pd_wr | input | 1 | Power-down control strobe |
| pd_val | input | 1 | New power-down bit value |
| sync_req | input | 1 | Request a sync pass without changing any word |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low frame select |
| spi_mosi | output | 1 | Serial data to the device |
| spi_load | output | 1 | One-cycle strobe after each frame |
| busy | output | 1 | A pass is running or pending |

## Verification
Errors in the written record show up at the ports as extra frames or missing frames in the next pass. They also show up on `host_rdata`, which can be read the cycle after any write. A stale double-buffer flag shows up at the end of the same pass as a missing or extra trailing word-0 frame. A lost pending request shows up as a dropped `busy` and as frames that never appear. A serializer counting error corrupts the very first frame: a wrong bit count, a shifted value or a misplaced index field.

// File: rtl/cfg_sync_pkg.sv
package cfg_sync_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_SCAN = 2'd1,
      SQ_XFER = 2'd2
   } seq_state_t;
endpackage

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank #(
   parameter int N      = 6,
   parameter int W      = 32,
   parameter int IW     = 3,
   parameter int PD_REG = 2,
   parameter int PD_BIT = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_wr,
   input  logic [IW-1:0]        host_addr,
   input  logic [W-1:0]         host_wdata,
   input  logic                 pd_wr,
   input  logic                 pd_val,
   input  logic                 hw_we,
   input  logic [IW-1:0]        hw_idx,
   input  logic [W-1:0]         hw_data,
   output logic [N-1:0][W-1:0]  shadow_q,
   output logic [N-1:0][W-1:0]  hw_q,
   output logic [W-1:0]         host_rdata
);
   for (genvar g = 0; g < N; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            shadow_q[g] <= '0;
            hw_q[g]     <= '1;
         end else begin
            if (host_wr && host_addr == IW'(g))
               shadow_q[g] <= {host_wdata[W-1:IW], {IW{1'b0}}};
            else if (pd_wr && g == PD_REG)
               shadow_q[g][PD_BIT] <= pd_val;
            if (hw_we && hw_idx == IW'(g))
               hw_q[g] <= hw_data;
         end
      end
   end

   always_comb begin
      host_rdata = '0;
      for (int i = 0; i < N; i++)
         if (host_addr == IW'(i)) host_rdata = hw_q[i];
   end
endmodule

// File: rtl/cfg_sync_seq.sv
module cfg_sync_seq
   import cfg_sync_pkg::*;
#(
   parameter int          N        = 6,
   parameter int          W        = 32,
   parameter int          IW       = 3,
   parameter logic [N-1:0] DBL_MASK = 6'b010010
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sync_req,
   input  logic [N-1:0][W-1:0]  shadow_q,
   input  logic [N-1:0][W-1:0]  hw_q,
   input  logic                 tx_done,
   output logic                 tx_start,
   output logic [W-1:0]         tx_word,
   output logic                 hw_we,
   output logic [IW-1:0]        hw_idx,
   output logic [W-1:0]         hw_data,
   output logic                 busy
);
   seq_state_t    st;
   logic [IW-1:0] idx;
   logic          dbl;
   logic          pend;
   logic [W-1:0]  held;
   logic          need;
   logic          last;

   assign need    = (shadow_q[idx] != hw_q[idx]) || (idx == '0 && dbl);
   assign last    = (idx == '0);
   assign busy    = (st != SQ_IDLE);
   assign hw_we   = (st == SQ_XFER) && tx_done;
   assign hw_idx  = idx;
   assign hw_data = held;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= SQ_IDLE;
         idx      <= '0;
         dbl      <= 1'b0;
         pend     <= 1'b0;
         held     <= '0;
         tx_word  <= '0;
         tx_start <= 1'b0;
      end else begin
         tx_start <= 1'b0;
         if (st != SQ_IDLE && sync_req) pend <= 1'b1;
         unique case (st)
            SQ_IDLE: if (sync_req) begin
               st   <= SQ_SCAN;
               idx  <= IW'(N-1);
               dbl  <= 1'b0;
               pend <= 1'b0;
            end
            SQ_SCAN: begin
               if (need) begin
                  held     <= shadow_q[idx];
                  tx_word  <= shadow_q[idx] | W'(idx);
                  tx_start <= 1'b1;
                  st       <= SQ_XFER;
                  if (DBL_MASK[idx]) dbl <= 1'b1;
               end else if (!last) begin
                  idx <= idx - 1'b1;
               end else if (pend || sync_req) begin
                  idx  <= IW'(N-1);
                  dbl  <= 1'b0;
                  pend <= 1'b0;
               end else begin
                  st <= SQ_IDLE;
               end
            end
            SQ_XFER: if (tx_done) begin
               if (!last) begin
                  idx <= idx - 1'b1;
                  st  <= SQ_SCAN;
               end else if (pend || sync_req) begin
                  idx  <= IW'(N-1);
                  dbl  <= 1'b0;
                  pend <= 1'b0;
                  st   <= SQ_SCAN;
               end else begin
                  st <= SQ_IDLE;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cfg_spi_tx.sv
module cfg_spi_tx #(
   parameter int W       = 32,
   parameter int CLK_DIV = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] word,
   output logic         sclk,
   output logic         cs_n,
   output logic         mosi,
   output logic         done
);
   localparam int BW = $clog2(W);
   localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   logic          active;
   logic [W-1:0]  shreg;
   logic [BW-1:0] bitcnt;
   logic          tick;

   if (CLK_DIV == 1) begin : g_nodiv
      assign tick = 1'b1;
   end else begin : g_div
      logic [DW-1:0] divcnt;
      assign tick = (divcnt == DW'(CLK_DIV-1));
      always_ff @(posedge clk) begin
         if (!rst_n || !active || tick) divcnt <= '0;
         else                           divcnt <= divcnt + 1'b1;
      end
   end

   assign mosi = shreg[W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         sclk   <= 1'b0;
         cs_n   <= 1'b1;
         shreg  <= '0;
         bitcnt <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            if (start) begin
               active <= 1'b1;
               cs_n   <= 1'b0;
               sclk   <= 1'b0;
               shreg  <= word;
               bitcnt <= '0;
            end
         end else if (tick) begin
            if (!sclk) begin
               sclk <= 1'b1;
            end else begin
               sclk <= 1'b0;
               if (bitcnt == BW'(W-1)) begin
                  active <= 1'b0;
                  cs_n   <= 1'b1;
                  done   <= 1'b1;
               end else begin
                  shreg  <= shreg << 1;
                  bitcnt <= bitcnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/cfg_shadow_sync.sv
module cfg_shadow_sync #(
   parameter int             NUM_REGS = 6,
   parameter int             WORD_W   = 32,
   parameter int             CLK_DIV  = 2,
   parameter int             PD_REG   = 2,
   parameter int             PD_BIT   = 5,
   parameter logic [5:0]     DBL_MASK = 6'b010010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [2:0]        host_addr,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_rdata,
   input  logic              pd_wr,
   input  logic              pd_val,
   input  logic              sync_req,
   output logic              spi_sclk,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   output logic              spi_load,
   output logic              busy
);
   localparam int IW = 3;

   if (NUM_REGS < 2 || NUM_REGS > (1 << IW)) begin : g_bad_n
      $error("NUM_REGS must lie in 2..8");
   end
   if (PD_BIT < IW || PD_BIT >= WORD_W || PD_REG >= NUM_REGS) begin : g_bad_pd
      $error("power-down bit must sit above the index field in an existing word");
   end
   if (CLK_DIV < 1 || NUM_REGS != 6) begin : g_bad_div
      $error("CLK_DIV must be at least 1 and NUM_REGS must match DBL_MASK width");
   end

   logic [NUM_REGS-1:0][WORD_W-1:0] shadow_q, hw_q;
   logic              hw_we, tx_start, tx_done, wr_ok, kick;
   logic [IW-1:0]     hw_idx;
   logic [WORD_W-1:0] hw_data, tx_word;

   assign wr_ok = host_wr && (int'(host_addr) < NUM_REGS);
   assign kick  = wr_ok || pd_wr || sync_req;

   cfg_shadow_bank #(.N(NUM_REGS), .W(WORD_W), .IW(IW), .PD_REG(PD_REG), .PD_BIT(PD_BIT)) u_bank (
      .clk(clk), .rst_n(rst_n), .host_wr(wr_ok), .host_addr(host_addr),
      .host_wdata(host_wdata), .pd_wr(pd_wr), .pd_val(pd_val),
      .hw_we(hw_we), .hw_idx(hw_idx), .hw_data(hw_data),
      .shadow_q(shadow_q), .hw_q(hw_q), .host_rdata(host_rdata)
   );

   cfg_sync_seq #(.N(NUM_REGS), .W(WORD_W), .IW(IW), .DBL_MASK(DBL_MASK)) u_seq (
      .clk(clk), .rst_n(rst_n), .sync_req(kick), .shadow_q(shadow_q), .hw_q(hw_q),
      .tx_done(tx_done), .tx_start(tx_start), .tx_word(tx_word),
      .hw_we(hw_we), .hw_idx(hw_idx), .hw_data(hw_data), .busy(busy)
   );

   cfg_spi_tx #(.W(WORD_W), .CLK_DIV(CLK_DIV)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(tx_start), .word(tx_word),
      .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .done(tx_done)
   );

   assign spi_load = tx_done;
endmodule

// File: rtl/cfg_sync_checks.sv
module cfg_sync_checks #(
   parameter int W = 32
) (
   input logic clk,
   input logic rst_n,
   input logic spi_sclk,
   input logic spi_cs_n,
   input logic spi_mosi,
   input logic spi_load,
   input logic busy
);
   logic        prev_sclk, prev_cs;
   logic [15:0] nrise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_sclk <= 1'b0;
         prev_cs   <= 1'b1;
         nrise     <= '0;
      end else begin
         prev_sclk <= spi_sclk;
         prev_cs   <= spi_cs_n;
         if (prev_cs && !spi_cs_n)                      nrise <= '0;
         else if (!spi_cs_n && spi_sclk && !prev_sclk)  nrise <= nrise + 1'b1;
      end
   end

   assert_sclk_low_at_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> !spi_sclk);
   assert_sclk_only_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sclk |-> !spi_cs_n);
   assert_mosi_steady_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
   assert_load_after_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
      spi_load |-> $rose(spi_cs_n));
   assert_load_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      spi_load |=> !spi_load);
   assert_frame_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> nrise == 16'(W));
   assert_frame_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_cs_n |-> busy);
endmodule

bind cfg_shadow_sync cfg_sync_checks #(.W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
   .spi_mosi(spi_mosi), .spi_load(spi_load), .busy(busy)
);

// File: tb/sim_cfg_shadow_sync.sv
module sim_cfg_shadow_sync;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [2:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        pd_wr = 1'b0, pd_val = 1'b0, sync_req = 1'b0;
   logic        spi_sclk, spi_cs_n, spi_mosi, spi_load, busy;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_shadow_sync u0 (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .pd_wr(pd_wr), .pd_val(pd_val),
      .sync_req(sync_req), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_load(spi_load), .busy(busy)
   );

   int checks = 0;
   int fails  = 0;

   // frame capture, sampled on the falling clock edge
   logic [31:0] cap [64];
   int          capbits [64];
   int          ncap = 0;
   int          busy_falls = 0;
   logic [31:0] sh = '0;
   int          bits = 0;
   logic        p_sclk = 1'b0, p_cs = 1'b1, p_busy = 1'b0;

   always @(negedge clk) begin
      if (p_cs && !spi_cs_n) bits = 0;
      if (!spi_cs_n && spi_sclk && !p_sclk) begin
         sh = {sh[30:0], spi_mosi};
         bits++;
      end
      if (spi_load && ncap < 64) begin
         cap[ncap] = sh;
         capbits[ncap] = bits;
         ncap++;
      end
      if (p_busy && !busy) busy_falls++;
      p_sclk = spi_sclk;
      p_cs   = spi_cs_n;
      p_busy = busy;
   end

   // bench model
   logic [31:0] m_sh [6];
   logic [31:0] m_hw [6];
   logic [31:0] exp_fr [16];
   int          exp_n;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic predict();
      logic dbl = 1'b0;
      exp_n = 0;
      for (int i = 5; i >= 0; i--) begin
         if (m_sh[i] != m_hw[i] || (i == 0 && dbl)) begin
            exp_fr[exp_n] = m_sh[i] | 32'(i);
            exp_n++;
            if (i == 1 || i == 4) dbl = 1'b1;
            m_hw[i] = m_sh[i];
         end
      end
   endtask

   task automatic wait_idle();
      repeat (2) @(negedge clk);
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic compare_frames(input string tag, input int base);
      chk({tag, " R3 frame count"}, 32'(ncap - base), 32'(exp_n));
      for (int k = 0; k < exp_n; k++) begin
         chk({tag, " R1 R2 R4 frame value"}, cap[base+k], exp_fr[k]);
         chk({tag, " R9 frame bit count"}, 32'(capbits[base+k]), 32'd32);
      end
   endtask

   task automatic host_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   // {addr, data, expected frame count}
   localparam logic [38:0] VEC [7] = '{
      {3'd3, 32'h1234_5677, 4'd1},   // R6 low bits cleared
      {3'd0, 32'hAAAA_0005, 4'd1},
      {3'd1, 32'h0000_8009, 4'd2},   // R4 word 0 follows word 1
      {3'd4, 32'h00C0_FFEF, 4'd2},   // R4 word 0 follows word 4
      {3'd3, 32'h1234_5670, 4'd0},   // R3 unchanged word not sent
      {3'd5, 32'h0058_0007, 4'd1},
      {3'd6, 32'hDEAD_BEEF, 4'd0}    // R6 bad index ignored
   };

   initial begin
      #(CLK_PERIOD * 150000);
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails + 1);
      $finish;
   end

   initial begin
      int base;
      logic [31:0] old;
      for (int i = 0; i < 6; i++) begin m_sh[i] = '0; m_hw[i] = '1; end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 reset state
      chk("R5 busy after reset", 32'(busy), 0);
      chk("R9 cs idle", 32'(spi_cs_n), 1);
      chk("R9 sclk idle", 32'(spi_sclk), 0);
      host_addr = 3'd0;
      #1 chk("R5 R7 record reads all ones", host_rdata, 32'hFFFF_FFFF);

      // R5 first sync sends all six words
      base = ncap;
      @(negedge clk); sync_req = 1'b1;
      @(negedge clk); sync_req = 1'b0;
      chk("R10 busy after request", 32'(busy), 1);
      predict();
      wait_idle();
      chk("R5 six frames", 32'(exp_n), 6);
      compare_frames("R5 first pass", base);

      // table walk
      for (int v = 0; v < 7; v++) begin
         logic [2:0]  a;
         logic [31:0] d;
         logic [3:0]  n;
         {a, d, n} = VEC[v];
         base = ncap;
         old = (a < 6) ? m_hw[a] : 32'h0;
         host_write(a, d);
         chk("R7 readback before frame", host_rdata, old);
         if (a < 6) m_sh[a] = {d[31:3], 3'b000};
         predict();
         wait_idle();
         chk("R3 R4 table frame count", 32'(exp_n), 32'(n));
         compare_frames("table", base);
         if (a < 6) chk("R6 R7 readback after sync", host_rdata, {d[31:3], 3'b000});
         else       chk("R7 bad index reads zero", host_rdata, 32'h0);
      end

      // R8 power-down set and clear
      for (int p = 1; p >= 0; p--) begin
         base = ncap;
         @(negedge clk); pd_wr = 1'b1; pd_val = p[0];
         @(negedge clk); pd_wr = 1'b0;
         m_sh[2][5] = p[0];
         predict();
         wait_idle();
         chk("R8 one frame", 32'(ncap - base), 1);
         compare_frames("R8 power-down", base);
         host_addr = 3'd2;
         #1 chk("R8 record bit 5", 32'(host_rdata[5]), 32'(p));
      end

      // R3 sync with nothing changed
      base = ncap;
      @(negedge clk); sync_req = 1'b1;
      @(negedge clk); sync_req = 1'b0;
      chk("R3 busy on empty pass", 32'(busy), 1);
      wait_idle();
      chk("R3 no frames on empty pass", 32'(ncap - base), 0);

      // R10 request during a pass is served by a second pass
      base = ncap;
      old = 32'(busy_falls);
      host_write(3'd3, 32'h0BAD_F00F);
      repeat (20) @(negedge clk);
      chk("R10 busy mid pass", 32'(busy), 1);
      host_write(3'd5, 32'h7700_0001);
      wait_idle();
      exp_n = 2;
      exp_fr[0] = 32'h0BAD_F00B;
      exp_fr[1] = 32'h7700_0005;
      m_sh[3] = 32'h0BAD_F008; m_hw[3] = m_sh[3];
      m_sh[5] = 32'h7700_0000; m_hw[5] = m_sh[5];
      compare_frames("R10 pending", base);
      chk("R10 busy fell once", 32'(busy_falls) - old, 1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule